// File: doc/BRIEF.md
# Auxiliary Interrupt Flag Controller

This block collects single-cycle event pulses from seven peripheral sources of a microcontroller and keeps one pending flag per source. Each flag is masked by a per-source enable register. The masked result is readable as an 8-bit status byte on the special-function-register (SFR) bus. The unmasked pending flags are readable at a second address, so software can poll sources that it has masked.

Software does not clear a flag by writing the status byte. Each flag clears as a side effect of the access that services its peripheral. Reading a timer's interrupt register, reading the low byte of a result register, or accessing the shared serial data register each clears its own flag. The low-voltage flag clears only when hardware reports that the analog supply has recovered.

The block drives a combined interrupt request and the index of the highest-priority enabled pending source. It also drives a hold line that stops the converter from overwriting its result registers while a conversion result is still unread. These auxiliary requests are not gated by any global enable.

Top module: `aux_irq_ctrl`

## Requirements
- R1: After reset, every pending flag and every enable bit is 0, so reads at A7h, A4h and A6h return 00h, `irq` is 0, `irq_src` is 0 and `adc_hold` is 0.
- R2: A read at address A7h returns the masked status. Bit b (for b = 7 down to 1) is 1 only when source b is pending and its enable bit is 1. Bit 0 is always 0. Source mapping: 7 seconds timer, 6 summation, 5 ADC, 4 millisecond timer, 3 I2C start/stop, 2 counter, 1 low-voltage detect. The pulse `src_evt[b]` sets flag b at the next clock edge.
- R3: A read at A4h returns the pending flags in bits 7..1 whatever the enables, with bit 0 at 0. A write at A6h loads `sfr_wdata[7:1]` into the enable bits. A read at A6h returns them with bit 0 at 0.
- R4: At the clock edge of a read, flag 7 clears for a read at F9h, flag 4 for a read at FAh, flag 6 for a read at E2h and flag 5 for a read at D9h. Writes to these addresses clear nothing.
- R5: A write at 9Bh clears flags 3 and 2. A read at 9Bh clears flag 2 only.
- R6: Flag 1 is cleared by no SFR access. It clears at a clock edge where `supply_ok` is 1.
- R7: When a source pulse and a clearing condition for the same flag fall in the same cycle, the flag is 1 after the edge.
- R8: `adc_hold` is 1 exactly while flag 5 is pending, whether or not it is enabled.
- R9: `irq` is 1 exactly when at least one flag is both pending and enabled.
- R10: `irq_src` gives the lowest-numbered flag that is pending and enabled (bit 1 has the highest priority, bit 7 the lowest). It is 0 when none is.
- R11: Reads at any other address return 00h, and accesses there change no flag and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd | input | 1 | Read strobe; clear side effects occur at the edge |
| sfr_wr | input | 1 | Write strobe |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| src_evt | input | 7 | Source event pulses, index b sets flag b (bits 7..1) |
| supply_ok | input | 1 | Analog supply above detect threshold; clears flag 1 |
| irq | output | 1 | Combined auxiliary interrupt request |
| irq_src | output | 3 | Highest-priority enabled pending source, 0 if none |
| adc_hold | output | 1 | Blocks result-register updates while the ADC flag is pending |

## Verification
`sfr_rdata` is combinational on the address, so the bench compares it in the same cycle the address is driven, a little after the falling edge. It uses the flag state from before the coming edge. An access or event becomes visible only after the next rising edge. Its effect on status, `irq`, `irq_src` and `adc_hold` is therefore checked at the falling edge of the following cycle. The bench's reference model advances its state at each rising edge to keep that one-cycle offset, and the directed checks read the raw view one cycle after each clearing access.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;

    localparam int DW     = 8;
    localparam int AW     = 8;
    localparam int IDXW   = 3;
    localparam int SRC_LO = 1;
    localparam int SRC_HI = DW - 1;

    // flag positions; priority decreases with rising position
    localparam int B_LVD = 1;
    localparam int B_CNT = 2;
    localparam int B_I2C = 3;
    localparam int B_MS  = 4;
    localparam int B_ADC = 5;
    localparam int B_SUM = 6;
    localparam int B_SEC = 7;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_STAT = 2'd1,
        RS_RAW  = 2'd2,
        RS_EN   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic            req;
        logic [IDXW-1:0] idx;
    } irq_out_t;

    function automatic logic [IDXW-1:0] first_set(input logic [SRC_HI:SRC_LO] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = SRC_HI; i >= SRC_LO; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/aux_sfr_decode.sv
module aux_sfr_decode
    import aux_irq_pkg::*;
#(
    parameter logic [AW-1:0] STAT_ADDR = 8'hA7,
    parameter logic [AW-1:0] RAW_ADDR  = 8'hA4,
    parameter logic [AW-1:0] EN_ADDR   = 8'hA6,
    parameter logic [AW-1:0] SEC_ADDR  = 8'hF9,
    parameter logic [AW-1:0] MS_ADDR   = 8'hFA,
    parameter logic [AW-1:0] SUM_ADDR  = 8'hE2,
    parameter logic [AW-1:0] ADC_ADDR  = 8'hD9,
    parameter logic [AW-1:0] SER_ADDR  = 8'h9B
) (
    input  logic [AW-1:0]      addr,
    input  logic               rd,
    input  logic               wr,
    output logic [SRC_HI:SRC_LO] sw_clr,
    output logic               en_wr,
    output rsel_e              rsel
);

    always_comb begin
        sw_clr        = '0;
        sw_clr[B_SEC] = rd && (addr == SEC_ADDR);
        sw_clr[B_MS]  = rd && (addr == MS_ADDR);
        sw_clr[B_SUM] = rd && (addr == SUM_ADDR);
        sw_clr[B_ADC] = rd && (addr == ADC_ADDR);
        sw_clr[B_I2C] = wr && (addr == SER_ADDR);
        sw_clr[B_CNT] = (rd || wr) && (addr == SER_ADDR);
    end

    assign en_wr = wr && (addr == EN_ADDR);

    always_comb begin
        unique case (addr)
            STAT_ADDR: rsel = RS_STAT;
            RAW_ADDR:  rsel = RS_RAW;
            EN_ADDR:   rsel = RS_EN;
            default:   rsel = RS_NONE;
        endcase
    end

endmodule

// File: rtl/aux_flag_bank.sv
module aux_flag_bank
    import aux_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_HI:SRC_LO] set_evt,
    input  logic [SRC_HI:SRC_LO] clr,
    output logic [SRC_HI:SRC_LO] pend
);

    for (genvar b = SRC_LO; b <= SRC_HI; b++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[b] <= 1'b0;
            else if (set_evt[b])
                pend[b] <= 1'b1;      // a new event beats a clear in the same cycle
            else if (clr[b])
                pend[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/aux_prio_enc.sv
module aux_prio_enc
    import aux_irq_pkg::*;
(
    input  logic [SRC_HI:SRC_LO] active,
    output irq_out_t             out
);

    always_comb begin
        out.req = |active;
        out.idx = first_set(active);
    end

endmodule

// File: rtl/aux_irq_ctrl.sv
module aux_irq_ctrl
    import aux_irq_pkg::*;
#(
    parameter logic [7:0] STAT_ADDR = 8'hA7,
    parameter logic [7:0] RAW_ADDR  = 8'hA4,
    parameter logic [7:0] EN_ADDR   = 8'hA6,
    parameter logic [7:0] SEC_ADDR  = 8'hF9,
    parameter logic [7:0] MS_ADDR   = 8'hFA,
    parameter logic [7:0] SUM_ADDR  = 8'hE2,
    parameter logic [7:0] ADC_ADDR  = 8'hD9,
    parameter logic [7:0] SER_ADDR  = 8'h9B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_rd,
    input  logic       sfr_wr,
    output logic [7:0] sfr_rdata,
    input  logic [7:1] src_evt,
    input  logic       supply_ok,
    output logic       irq,
    output logic [2:0] irq_src,
    output logic       adc_hold
);

    logic [SRC_HI:SRC_LO] sw_clr;
    logic [SRC_HI:SRC_LO] all_clr;
    logic [SRC_HI:SRC_LO] pend_q;
    logic [SRC_HI:SRC_LO] en_q;
    logic                 en_wr;
    rsel_e                rsel;
    irq_out_t             pri;
    logic                 wdata_lsb_unused;

    aux_sfr_decode #(
        .STAT_ADDR(STAT_ADDR), .RAW_ADDR(RAW_ADDR), .EN_ADDR(EN_ADDR),
        .SEC_ADDR(SEC_ADDR),   .MS_ADDR(MS_ADDR),   .SUM_ADDR(SUM_ADDR),
        .ADC_ADDR(ADC_ADDR),   .SER_ADDR(SER_ADDR)
    ) u_dec (
        .addr   (sfr_addr),
        .rd     (sfr_rd),
        .wr     (sfr_wr),
        .sw_clr (sw_clr),
        .en_wr  (en_wr),
        .rsel   (rsel)
    );

    // the supply-recovered line is the only clear source of the low-voltage flag
    always_comb begin
        all_clr        = sw_clr;
        all_clr[B_LVD] = supply_ok;
    end

    aux_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_evt (src_evt),
        .clr     (all_clr),
        .pend    (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (en_wr)
            en_q <= sfr_wdata[SRC_HI:SRC_LO];
    end

    assign wdata_lsb_unused = sfr_wdata[0];

    aux_prio_enc u_pri (
        .active (pend_q & en_q),
        .out    (pri)
    );

    always_comb begin
        unique case (rsel)
            RS_STAT: sfr_rdata = {pend_q & en_q, 1'b0};
            RS_RAW:  sfr_rdata = {pend_q, 1'b0};
            RS_EN:   sfr_rdata = {en_q, 1'b0};
            default: sfr_rdata = '0;
        endcase
    end

    assign irq      = pri.req;
    assign irq_src  = pri.idx;
    assign adc_hold = pend_q[B_ADC];

endmodule

// File: rtl/aux_irq_chk.sv
module aux_irq_chk #(
    parameter logic [7:0] STAT_ADDR = 8'hA7,
    parameter logic [7:0] SEC_ADDR  = 8'hF9,
    parameter logic [7:0] ADC_ADDR  = 8'hD9,
    parameter logic [7:0] SER_ADDR  = 8'h9B
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] sfr_addr,
    input logic       sfr_rd,
    input logic       sfr_wr,
    input logic [7:0] sfr_rdata,
    input logic [7:1] src_evt,
    input logic       supply_ok,
    input logic       irq,
    input logic [2:0] irq_src,
    input logic       adc_hold,
    input logic [7:1] pend,
    input logic [7:1] en
);

    logic [7:0] act8;
    assign act8 = {pend & en, 1'b0};

    a_r2_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == STAT_ADDR) |-> !sfr_rdata[0])
        else $error("R2 status bit 0 not zero");

    for (genvar b = 1; b < 8; b++) begin : g_set
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            src_evt[b] |=> pend[b])
            else $error("R7 event lost");
    end

    a_r4_write_no_clear: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && !sfr_rd && sfr_addr == SEC_ADDR && pend[7]) |=> pend[7])
        else $error("R4 write cleared seconds flag");

    a_r5_read_keeps_i2c: assert property (@(posedge clk) disable iff (rst)
        (sfr_rd && !sfr_wr && sfr_addr == SER_ADDR && pend[3]) |=> pend[3])
        else $error("R5 read cleared I2C flag");

    a_r6_lvd_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend[1] && !supply_ok) |=> pend[1])
        else $error("R6 low-voltage flag cleared without supply recovery");

    a_r6_lvd_hw_clear: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && !src_evt[1]) |=> !pend[1])
        else $error("R6 low-voltage flag not cleared");

    a_r8_hold_released: assert property (@(posedge clk) disable iff (rst)
        (sfr_rd && sfr_addr == ADC_ADDR && !src_evt[5]) |=> !adc_hold)
        else $error("R8 hold stuck");

    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (adc_hold && !(sfr_rd && sfr_addr == ADC_ADDR)) |=> adc_hold)
        else $error("R8 hold dropped");

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (act8 == 8'h00 && irq_src == 3'd0))
        else $error("R9 idle mismatch");

    a_r10_src_active: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_src != 3'd0 && act8[irq_src]))
        else $error("R10 index not active");

    a_r10_none_higher: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((act8 & ((8'd1 << irq_src) - 8'd1)) == 8'h00))
        else $error("R10 higher priority source skipped");

endmodule

bind aux_irq_ctrl aux_irq_chk #(
    .STAT_ADDR(STAT_ADDR), .SEC_ADDR(SEC_ADDR),
    .ADC_ADDR(ADC_ADDR),   .SER_ADDR(SER_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_rdata (sfr_rdata),
    .src_evt   (src_evt),
    .supply_ok (supply_ok),
    .irq       (irq),
    .irq_src   (irq_src),
    .adc_hold  (adc_hold),
    .pend      (pend_q),
    .en        (en_q)
);

// File: tb/sim_aux_irq_ctrl.sv
module sim_aux_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_rd = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_rdata;
    logic [7:1] src_evt = '0;
    logic       supply_ok = 1'b0;
    logic       irq;
    logic [2:0] irq_src;
    logic       adc_hold;

    int checks = 0;
    int errors = 0;
    logic [7:1] m_pend = '0;
    logic [7:1] m_en   = '0;
    logic [7:0] got_rd;

    aux_irq_ctrl u0 (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_rdata(sfr_rdata),
        .src_evt(src_evt), .supply_ok(supply_ok), .irq(irq),
        .irq_src(irq_src), .adc_hold(adc_hold)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:1] exp_clr(input logic [7:0] a, input logic rd,
                                           input logic wr, input logic sok);
        logic [7:1] c = '0;
        c[7] = rd && a == 8'hF9;
        c[4] = rd && a == 8'hFA;
        c[6] = rd && a == 8'hE2;
        c[5] = rd && a == 8'hD9;
        c[3] = wr && a == 8'h9B;
        c[2] = (rd || wr) && a == 8'h9B;
        c[1] = sok;
        return c;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'hA7:   return {m_pend & m_en, 1'b0};
            8'hA4:   return {m_pend, 1'b0};
            8'hA6:   return {m_en, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] exp_src(input logic [7:1] act);
        for (int i = 1; i <= 7; i++) if (act[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic string rd_req(input logic [7:0] a);
        case (a)
            8'hA7:        return "R2";
            8'hA4, 8'hA6: return "R3";
            default:      return "R11";
        endcase
    endfunction

    // one bus cycle: drive after the falling edge, compare, then advance the model
    task automatic step(input logic [7:0] a, input logic [7:0] wd, input logic rd,
                        input logic wr, input logic [7:1] ev, input logic sok);
        logic [7:1] c;
        @(negedge clk);
        sfr_addr = a; sfr_wdata = wd; sfr_rd = rd; sfr_wr = wr;
        src_evt = ev; supply_ok = sok;
        #1;
        got_rd = sfr_rdata;
        chk(rd_req(a), int'(sfr_rdata), int'(exp_rdata(a)));
        chk("R9",  int'(irq), int'(|(m_pend & m_en)));
        chk("R10", int'(irq_src), int'(exp_src(m_pend & m_en)));
        chk("R8",  int'(adc_hold), int'(m_pend[5]));
        @(posedge clk);
        c = exp_clr(a, rd, wr, sok);
        m_pend = ev | (m_pend & ~c);
        if (wr && a == 8'hA6) m_en = wd[7:1];
    endtask

    task automatic peek(input logic [7:0] a);
        step(a, 8'h00, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] alist [10] = '{8'hA7, 8'hA4, 8'hA6, 8'hF9, 8'hFA,
                                   8'hE2, 8'hD9, 8'h9B, 8'h55, 8'h00};
        int seed;
        seed = $urandom(32'd1234);
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        peek(8'hA7); chk("R1", int'(got_rd), 0);
        peek(8'hA4); chk("R1", int'(got_rd), 0);
        peek(8'hA6); chk("R1", int'(got_rd), 0);
        chk("R1", int'({irq, irq_src, adc_hold}), 0);

        // R2 / R10 / R8: everything enabled and pending
        step(8'hA6, 8'hFF, 1'b0, 1'b1, '0, 1'b0);
        step(8'h00, 8'h00, 1'b0, 1'b0, 7'h7F, 1'b0);
        peek(8'hA7); chk("R2", int'(got_rd), 'hFE);
        chk("R10", int'(irq_src), 1);
        chk("R8", int'(adc_hold), 1);

        // R4 clears by read
        step(8'hF9, 8'h00, 1'b1, 1'b0, '0, 1'b0);
        peek(8'hA4); chk("R4", int'(got_rd), 'h7E);
        step(8'hFA, 8'h00, 1'b1, 1'b0, '0, 1'b0);
        peek(8'hA4); chk("R4", int'(got_rd), 'h6E);
        step(8'hE2, 8'h00, 1'b1, 1'b0, '0, 1'b0);
        peek(8'hA4); chk("R4", int'(got_rd), 'h2E);
        step(8'hD9, 8'h00, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA4); chk("R4", int'(got_rd), 'h2E);
        step(8'hD9, 8'h00, 1'b1, 1'b0, '0, 1'b0);
        peek(8'hA4); chk("R4", int'(got_rd), 'h0E);
        chk("R8", int'(adc_hold), 0);

        // R5 shared serial register
        step(8'h9B, 8'h00, 1'b1, 1'b0, '0, 1'b0);
        peek(8'hA4); chk("R5", int'(got_rd), 'h0A);
        step(8'h9B, 8'h00, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA4); chk("R5", int'(got_rd), 'h02);

        // R6 low-voltage flag
        foreach (alist[i]) step(alist[i], 8'h00, 1'b1, 1'b0, '0, 1'b0);
        step(8'hA6, 8'hFF, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA4); chk("R6", int'(got_rd), 'h02);
        step(8'h00, 8'h00, 1'b0, 1'b0, '0, 1'b1);
        peek(8'hA4); chk("R6", int'(got_rd), 'h00);

        // R7 set beats clear
        step(8'hF9, 8'h00, 1'b1, 1'b0, 7'h40, 1'b0);
        peek(8'hA4); chk("R7", int'(got_rd), 'h80);
        step(8'h00, 8'h00, 1'b0, 1'b0, 7'h01, 1'b1);
        peek(8'hA4); chk("R7", int'(got_rd), 'h82);

        // R9 / R10 masking and priority
        step(8'hA6, 8'h00, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA7); chk("R2", int'(got_rd), 0);
        chk("R9", int'(irq), 0); chk("R10", int'(irq_src), 0);
        step(8'hA6, 8'h80, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA7); chk("R9", int'(irq), 1); chk("R10", int'(irq_src), 7);
        step(8'hA6, 8'h82, 1'b0, 1'b1, '0, 1'b0);
        peek(8'hA7); chk("R10", int'(irq_src), 1);

        // R11 unmapped access
        step(8'h55, 8'hFF, 1'b1, 1'b1, '0, 1'b0);
        chk("R11", int'(got_rd), 0);
        peek(8'hA4); chk("R11", int'(got_rd), 'h82);
        peek(8'hA6); chk("R11", int'(got_rd), 'h82);

        // constrained random traffic
        for (int n = 0; n < N_RAND; n++) begin
            logic [7:1] ev;
            ev = 7'($urandom) & 7'($urandom) & 7'($urandom);
            step(alist[$urandom % 10], 8'($urandom), 1'($urandom), 1'($urandom % 3 == 0),
                 ev, 1'($urandom % 8 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule